// File: doc/BRIEF.md
# Four-Channel Countdown Timer with Register Slave

The block is a timer peripheral with four independent down-counters behind a single APB-style register slave. Every channel has its own 64-byte register window. In it, software selects single-shot or auto-repeat operation, sets a preset count, starts and stops the counter, forces a reload, reads the live count, masks the interrupt and acknowledges a pending event. Offset zero of every window returns one word that collects the pending flags of all channels. Each channel drives its own interrupt line.

A channel copies its preset into the counter when it is started. It then counts down by one on every clock. When the count steps from one to zero, the channel raises a pending flag, which stays set until software acknowledges it. A single-shot channel then rests at zero. A repeating channel reloads the preset and continues. An acknowledge starts a short busy window, and during that window further acknowledges are refused. Transfers complete without wait states. Read data is valid during the access phase.

Top module: `qtmr_top`

## Requirements
- R1: After reset, every channel is stopped and in repeat mode, with its mask set to 1, its preset, count and pending flag at 0, and its interrupt line low.
- R2: Address bits [7:6] select the channel window and bits [5:0] select the register. The offsets are 0x04 mode, 0x08 preset, 0x10 run, 0x14 reload, 0x18 count (read-only), 0x20 acknowledge and 0x24 mask. Offset 0x00 of any window reads the pending flags, with channel n's flag at bit n.
- R3: Writing 1 to run bit 0 of a stopped channel copies the preset into the counter and starts it. Writing 0 stops the channel, and the count then holds its value.
- R4: A running channel decrements once per clock. In single-shot mode (mode bit 0 = 1), it stays at zero once it gets there. In repeat mode (mode bit 0 = 0), it reloads the preset on the clock after zero, so the count cycles with a period of preset+1 clocks.
- R5: The pending flag is set on the clock at which a running counter steps from 1 to 0. It stays set until an acknowledge succeeds.
- R6: A write to the preset register leaves the counter unchanged. A write of any data to the reload register copies the preset into the counter.
- R7: Reading the acknowledge register returns the pending flag in bit 0 and the busy flag in bit 1. Writing 1 to bit 0 clears the pending flag and holds busy at 1 for the next two clocks. Writing 0 to bit 0 has no effect.
- R8: An acknowledge write that arrives while busy is 1 is ignored, and the pending flag keeps its value.
- R9: Interrupt line n equals channel n's pending flag while mask bit 0 is 0. It is low while the mask is 1, and the mask does not change the pending flag.
- R10: The count register returns the live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | 8 | Byte address: channel window and register offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
The hardest case to reach is an acknowledge refused by the busy window at a moment when the refusal is visible. The pending flag must have been raised again between the two acknowledges. Otherwise a refused clear and a successful one leave the same state. The stimulus gets there with a repeat channel whose period is four clocks. Back-to-back writes place the first acknowledge just before a zero crossing and the second one inside the busy window. The pending flag is then read before the next crossing. Randomized presets, modes, masks and wait lengths check the count and pending state against a bench model of the countdown.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;

    localparam int WIN_BITS = 6;

    localparam logic [WIN_BITS-1:0] OFF_STATUS = 6'h00;
    localparam logic [WIN_BITS-1:0] OFF_MODE   = 6'h04;
    localparam logic [WIN_BITS-1:0] OFF_LOAD   = 6'h08;
    localparam logic [WIN_BITS-1:0] OFF_RUN    = 6'h10;
    localparam logic [WIN_BITS-1:0] OFF_RELOAD = 6'h14;
    localparam logic [WIN_BITS-1:0] OFF_COUNT  = 6'h18;
    localparam logic [WIN_BITS-1:0] OFF_ACK    = 6'h20;
    localparam logic [WIN_BITS-1:0] OFF_MASK   = 6'h24;

    typedef enum logic {
        MODE_REPEAT = 1'b0,
        MODE_ONCE   = 1'b1
    } run_mode_e;

    // one write strobe per register of a channel window
    typedef struct packed {
        logic mode;
        logic load;
        logic run;
        logic reload;
        logic ack;
        logic mask;
    } ch_wr_t;

    // control and flag state of one channel
    typedef struct packed {
        logic single;
        logic run;
        logic mask;
        logic pending;
        logic busy;
    } ch_st_t;

    function automatic logic [1:0] ack_word(input ch_st_t s);
        return {s.busy, s.pending};
    endfunction

endpackage

// File: rtl/qtmr_chan.sv
module qtmr_chan
    import qtmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int DATA_W   = 32,
    parameter int BUSY_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_wr_t            wr,
    input  logic [DATA_W-1:0] wdata,
    output ch_st_t            st,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  load,
    output logic              irq
);

    localparam int BUSY_W = $clog2(BUSY_CYC + 1);

    run_mode_e         mode;
    logic              run;
    logic              mask;
    logic              pending;
    logic [BUSY_W-1:0] busy_cnt;

    logic busy;
    logic start;
    logic force_ld;
    logic hit;
    logic ack_ok;

    always_comb begin
        busy     = (busy_cnt != '0);
        start    = wr.run && wdata[0] && !run;
        force_ld = wr.reload || start;
        hit      = run && !force_ld && (cnt == CNT_W'(1));
        ack_ok   = wr.ack && wdata[0] && !busy;
    end

    // control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_REPEAT;
            run  <= 1'b0;
            mask <= 1'b1;
            load <= '0;
        end else begin
            if (wr.mode)
                mode <= run_mode_e'(wdata[0]);
            if (wr.run)
                run <= wdata[0];
            if (wr.mask)
                mask <= wdata[0];
            if (wr.load)
                load <= wdata[CNT_W-1:0];
        end
    end

    // countdown
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (force_ld) begin
            cnt <= load;
        end else if (run) begin
            if (cnt != '0)
                cnt <= cnt - CNT_W'(1);
            else if (mode == MODE_REPEAT)
                cnt <= load;
        end
    end

    // pending flag and acknowledge busy window; a new event wins over a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            busy_cnt <= '0;
        end else begin
            if (hit)
                pending <= 1'b1;
            else if (ack_ok)
                pending <= 1'b0;

            if (ack_ok)
                busy_cnt <= BUSY_W'(BUSY_CYC);
            else if (busy)
                busy_cnt <= busy_cnt - BUSY_W'(1);
        end
    end

    assign irq = pending & ~mask;

    always_comb begin
        st.single  = (mode == MODE_ONCE);
        st.run     = run;
        st.mask    = mask;
        st.pending = pending;
        st.busy    = busy;
    end

endmodule

// File: rtl/qtmr_regdec.sv
module qtmr_regdec
    import qtmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [ADDR_W-1:0]             paddr,
    input  ch_st_t [NUM_CH-1:0]           st,
    input  logic   [NUM_CH-1:0][CNT_W-1:0] cnt,
    input  logic   [NUM_CH-1:0][CNT_W-1:0] load,
    output ch_wr_t [NUM_CH-1:0]           wr,
    output logic   [DATA_W-1:0]           prdata
);

    localparam int IDX_W = ADDR_W - WIN_BITS;

    logic [IDX_W-1:0]    idx;
    logic [WIN_BITS-1:0] off;
    logic                acc;
    logic [NUM_CH-1:0]   pend_vec;

    assign idx = paddr[ADDR_W-1:WIN_BITS];
    assign off = paddr[WIN_BITS-1:0];
    assign acc = psel & penable & pwrite;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        logic sel;
        assign sel          = acc && (idx == IDX_W'(i));
        assign wr[i].mode   = sel && (off == OFF_MODE);
        assign wr[i].load   = sel && (off == OFF_LOAD);
        assign wr[i].run    = sel && (off == OFF_RUN);
        assign wr[i].reload = sel && (off == OFF_RELOAD);
        assign wr[i].ack    = sel && (off == OFF_ACK);
        assign wr[i].mask   = sel && (off == OFF_MASK);
        assign pend_vec[i]  = st[i].pending;
    end

    always_comb begin
        prdata = '0;
        if (psel) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (idx == IDX_W'(i)) begin
                    case (off)
                        OFF_STATUS: prdata = DATA_W'(pend_vec);
                        OFF_MODE:   prdata = DATA_W'(st[i].single);
                        OFF_LOAD:   prdata = DATA_W'(load[i]);
                        OFF_RUN:    prdata = DATA_W'(st[i].run);
                        OFF_COUNT:  prdata = DATA_W'(cnt[i]);
                        OFF_ACK:    prdata = DATA_W'(ack_word(st[i]));
                        OFF_MASK:   prdata = DATA_W'(st[i].mask);
                        default:    prdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/qtmr_top.sv
module qtmr_top
    import qtmr_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 32,
    parameter int BUSY_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic [NUM_CH-1:0] irq
);

    ch_wr_t [NUM_CH-1:0]            ch_wr;
    ch_st_t [NUM_CH-1:0]            ch_st;
    logic   [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
    logic   [NUM_CH-1:0][CNT_W-1:0] ch_load;

    qtmr_regdec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regdec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .st      (ch_st),
        .cnt     (ch_cnt),
        .load    (ch_load),
        .wr      (ch_wr),
        .prdata  (prdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        qtmr_chan #(
            .CNT_W    (CNT_W),
            .DATA_W   (DATA_W),
            .BUSY_CYC (BUSY_CYC)
        ) u_chan (
            .clk   (clk),
            .rst   (rst),
            .wr    (ch_wr[i]),
            .wdata (pwdata),
            .st    (ch_st[i]),
            .cnt   (ch_cnt[i]),
            .load  (ch_load[i]),
            .irq   (irq[i])
        );
    end

endmodule

// File: rtl/qtmr_chk.sv
module qtmr_chk
    import qtmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic   [NUM_CH-1:0]           irq,
    input ch_st_t [NUM_CH-1:0]           st,
    input logic   [NUM_CH-1:0][CNT_W-1:0] cnt,
    input ch_wr_t [NUM_CH-1:0]           wr
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        p_once_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (st[i].run && st[i].single && cnt[i] == '0 && !wr[i].reload)
            |=> (cnt[i] == '0));

        p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
            (st[i].run && cnt[i] != '0 && !wr[i].reload && !wr[i].run)
            |=> (cnt[i] == $past(cnt[i]) - CNT_W'(1)));

        p_pend_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(st[i].pending) |-> (cnt[i] == '0));

        p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
            $rose(st[i].busy) |=> st[i].busy);

        p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
            (st[i].busy && $past(st[i].busy)) |=> !st[i].busy);

        p_ack_refused_r8: assert property (@(posedge clk) disable iff (rst)
            (st[i].busy && wr[i].ack && st[i].pending) |=> st[i].pending);

        p_mask_blocks_r9: assert property (@(posedge clk) disable iff (rst)
            st[i].mask |-> !irq[i]);

        p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> st[i].pending);
    end

endmodule

bind qtmr_top qtmr_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_qtmr_chk (
    .clk (clk),
    .rst (rst),
    .irq (irq),
    .st  (ch_st),
    .cnt (ch_cnt),
    .wr  (ch_wr)
);

// File: tb/test_qtmr_top.sv
module test_qtmr_top;

    localparam logic [5:0] A_STAT = 6'h00;
    localparam logic [5:0] A_MODE = 6'h04;
    localparam logic [5:0] A_LOAD = 6'h08;
    localparam logic [5:0] A_RUN  = 6'h10;
    localparam logic [5:0] A_RLD  = 6'h14;
    localparam logic [5:0] A_CNT  = 6'h18;
    localparam logic [5:0] A_ACK  = 6'h20;
    localparam logic [5:0] A_MASK = 6'h24;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [7:0]  paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic [3:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    qtmr_top i_qtmr_top (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [5:0] off, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = {2'(ch), off}; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input int ch, input logic [5:0] off,
                      output logic [31:0] d, output int t);
        psel = 1'b1; pwrite = 1'b0; paddr = {2'(ch), off};
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        t = cyc;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [31:0] exp_count(input int l, input int k, input bit once);
        if (once) return (k >= l) ? 32'd0 : 32'(l - k);
        return 32'(l - (k % (l + 1)));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        int t, t0;
        void'($urandom(32'h1bad_5eed));
        rst = 1'b1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < 4; c++) begin
            rd(c, A_MODE, d, t); check("R1", "mode", d, 32'd0);
            rd(c, A_RUN,  d, t); check("R1", "run", d, 32'd0);
            rd(c, A_MASK, d, t); check("R1", "mask", d, 32'd1);
            rd(c, A_LOAD, d, t); check("R1", "preset", d, 32'd0);
            rd(c, A_CNT,  d, t); check("R1", "count", d, 32'd0);
            rd(c, A_ACK,  d, t); check("R1", "ack", d, 32'd0);
        end
        rd(2, A_STAT, d, t); check("R1", "status", d, 32'd0);
        check("R1", "irq", 32'(irq), 32'd0);

        // R6 preset write vs reload strobe on a stopped channel
        wr(1, A_LOAD, 32'h0000_1234);
        wr(1, A_RLD, 32'd0);
        rd(1, A_CNT, d, t); check("R6", "reload data 0", d, 32'h0000_1234);
        wr(1, A_LOAD, 32'h0000_0055);
        rd(1, A_CNT, d, t); check("R6", "preset write keeps count", d, 32'h0000_1234);
        wr(1, A_RLD, 32'd1);
        rd(1, A_CNT, d, t); check("R6", "reload data 1", d, 32'h0000_0055);

        // R2 R3 R4 R5 R9 R10 randomized countdown against model
        for (int it = 0; it < 24; it++) begin
            int  c, l, w;
            bit  once, m;
            c    = int'($urandom % 4);
            l    = 2 + int'($urandom % 40);
            w    = int'($urandom % 60);
            once = 1'($urandom % 2);
            m    = 1'($urandom % 2);
            wr(c, A_RUN, 32'd0);
            wr(c, A_MODE, 32'(once));
            wr(c, A_LOAD, 32'(l));
            wr(c, A_MASK, 32'(m));
            wr(c, A_RUN, 32'd1);
            t0 = cyc;
            repeat (w) @(negedge clk);
            rd(c, A_CNT, d, t);
            check("R10", "live count", d, exp_count(l, t - t0, once));
            rd((c + it) % 4, A_STAT, d, t);
            check("R5", "status word", d, ((t - t0) >= l) ? (32'd1 << c) : 32'd0);
            check("R9", "irq line", 32'(irq[c]), 32'(((cyc - t0) >= l) && !m));
            wr(c, A_RUN, 32'd0);
            rd(c, A_CNT, d, t);
            repeat (5) @(negedge clk);
            rd(c, A_CNT, d2, t);
            check("R3", "stopped count holds", d2, d);
            wr(c, A_ACK, 32'd1);
        end

        // R4 R5 R7 R9 single-shot pending, masking, acknowledge
        wr(2, A_MODE, 32'd1);
        wr(2, A_LOAD, 32'd3);
        wr(2, A_MASK, 32'd1);
        wr(2, A_RUN, 32'd1);
        repeat (10) @(negedge clk);
        rd(2, A_ACK, d, t); check("R5", "pending while masked", d, 32'd1);
        check("R9", "masked irq low", 32'(irq[2]), 32'd0);
        rd(2, A_CNT, d, t); check("R4", "single-shot rests at 0", d, 32'd0);
        wr(2, A_MASK, 32'd0);
        check("R9", "unmasked irq high", 32'(irq[2]), 32'd1);
        wr(2, A_ACK, 32'd0);
        rd(2, A_ACK, d, t); check("R7", "write 0 no effect", d, 32'd1);
        wr(2, A_ACK, 32'd1);
        rd(2, A_ACK, d, t); check("R7", "busy after clear", d, 32'd2);
        check("R9", "irq low after clear", 32'(irq[2]), 32'd0);
        rd(2, A_ACK, d, t); check("R7", "busy over", d, 32'd0);

        // R8 refused acknowledge: repeat period 4, flag re-raised inside busy window
        wr(3, A_MODE, 32'd0);
        wr(3, A_LOAD, 32'd3);
        wr(3, A_RUN, 32'd1);
        wr(3, A_MASK, 32'd0);
        wr(3, A_MODE, 32'd0);
        wr(3, A_ACK, 32'd1);
        wr(3, A_ACK, 32'd1);
        rd(0, A_STAT, d, t); check("R8", "pending kept", d, 32'h0000_0008);
        check("R8", "irq kept", 32'(irq), 32'h0000_0008);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule